// File: doc/BRIEF.md
# Adder-Based Up/Down Counter

This block is a small binary counter that steps up, steps down or holds, one step per clock. It does not use per-bit toggle logic. A register feeds a ripple-carry adder, and the adder's sum is written back on every clock edge. The second adder operand comes from the two direction lines. The count-down line drives every operand bit. The count-up line drives the adder's carry-in. The resulting increments are:

- +1 when counting up.
- All ones, which is −1 modulo 2^W, when counting down.
- Zero when idle.

Raising both direction lines is not a legal request. In that case the block adds nothing, so the count holds, and it raises a conflict flag for as long as the request is present. The width defaults to 3 bits and is set by a parameter. Any carry out of the top bit is dropped, so the count wraps.

Top module: `ud_adder_counter`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `count` becomes 0 after that edge (synchronous reset).
- R2: When `up`=1 and `dn`=0 (and `rst`=0), `count` becomes (previous `count` + 1) mod 2^W after the edge.
- R3: When `up`=0 and `dn`=1, `count` becomes (previous `count` − 1) mod 2^W after the edge; 0 steps to 2^W−1 (7 for W=3).
- R4: When `up`=0 and `dn`=0, `count` keeps its value across the edge.
- R5: When `up`=1 and `dn`=1, `count` keeps its value across the edge and `conflict` is 1 in that same cycle. `conflict` is 0 whenever the two lines are not both high.
- R6: Counting up from 2^W−1 gives 0. The adder's carry out is discarded.
- R7: `rst` takes priority over `up` and `dn`. A reset edge yields 0 whatever the direction lines carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| up | input | 1 | Request to count up |
| dn | input | 1 | Request to count down |
| count | output | W (3) | Present count value |
| conflict | output | 1 | High while `up` and `dn` are both high (combinational) |

## Verification
The hardest behaviour to reach is the interaction of the borrow and carry chains at the wrap points, taken in both directions back to back:

- 0 stepping down to all ones.
- All ones stepping up to 0.

A free-running sequence visits these edges only occasionally. The directed tasks therefore walk the counter onto each edge on purpose and then reverse the direction.

The conflict case is reached directly by raising both lines on a nonzero count. This shows that the hold is a true hold and not a wrap.

A long stream of random legal direction pairs is then compared against a modulo model.

// File: rtl/ud_pkg.sv
package ud_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_UP    = 2'd1,
        STEP_DOWN  = 2'd2,
        STEP_CLASH = 2'd3
    } step_e;
endpackage

// File: rtl/ud_step_operand.sv
module ud_step_operand
    import ud_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             up,
    input  logic             dn,
    output logic [WIDTH-1:0] operand,
    output logic             carry_in,
    output step_e            step
);
    logic clash;

    always_comb begin
        clash = up & dn;
        // Down drives every operand bit (all ones = -1); up enters as carry-in.
        operand  = clash ? '0 : {WIDTH{dn}};
        carry_in = clash ? 1'b0 : up;
        unique case ({up, dn})
            2'b10:   step = STEP_UP;
            2'b01:   step = STEP_DOWN;
            2'b11:   step = STEP_CLASH;
            default: step = STEP_HOLD;
        endcase
    end
endmodule

// File: rtl/ud_ripple_adder.sv
module ud_ripple_adder #(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum
);
    // Carry into each bit; the carry out of the top bit is never formed.
    logic [WIDTH-1:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i] = a[i] ^ b[i] ^ carry[i];
        if (i < WIDTH - 1) begin : g_chain
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
    end
endmodule

// File: rtl/ud_adder_counter.sv
module ud_adder_counter
    import ud_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up,
    input  logic             dn,
    output logic [WIDTH-1:0] count,
    output logic             conflict
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } state_t;

    state_t           state_d, state_q;
    logic [WIDTH-1:0] operand;
    logic             carry_in;
    logic [WIDTH-1:0] sum;
    step_e            step;

    ud_step_operand #(.WIDTH(WIDTH)) i_operand (
        .up       (up),
        .dn       (dn),
        .operand  (operand),
        .carry_in (carry_in),
        .step     (step)
    );

    ud_ripple_adder #(.WIDTH(WIDTH)) i_adder (
        .a   (state_q.count),
        .b   (operand),
        .cin (carry_in),
        .sum (sum)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.count = '0;
        end else begin
            state_d.count = sum;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count    = state_q.count;
    assign conflict = (step == STEP_CLASH);

    // R1 / R7: a reset edge clears the count whatever the direction lines carry.
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> count == '0);

    // R2 and R6: step up by one, wrapping.
    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (up && !dn) |=> count == WIDTH'($past(count) + ONE));

    // R3: step down by one, wrapping.
    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (!up && dn) |=> count == WIDTH'($past(count) - ONE));

    // R4: idle holds.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!up && !dn) |=> $stable(count));

    // R5: a clash holds the count.
    p_clash_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (up && dn) |=> $stable(count));

    // R5: the flag tracks the clash.
    p_clash_flag_r5: assert property (@(posedge clk)
        conflict == (up && dn));
endmodule

// File: tb/test_ud_adder_counter.sv
module test_ud_adder_counter;
    localparam int W = 3;
    localparam int MOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         up = 1'b0;
    logic         dn = 1'b0;
    logic [W-1:0] count;
    logic         conflict;

    int n_tests = 0;
    int n_fail = 0;
    int model = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ud_adder_counter #(.WIDTH(W)) i_ud_adder_counter (
        .clk      (clk),
        .rst      (rst),
        .up       (up),
        .dn       (dn),
        .count    (count),
        .conflict (conflict)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Drive one cycle; check conflict before the edge and count after it.
    task automatic cycle(input logic r, input logic u, input logic d, input string req);
        @(negedge clk);
        rst = r;
        up  = u;
        dn  = d;
        #1;
        check({req, " conflict"}, int'(conflict), int'(u & d));
        if (r) model = 0;
        else if (u && !d) model = (model + 1) % MOD;
        else if (!u && d) model = (model + MOD - 1) % MOD;
        @(posedge clk);
        #1;
        check({req, " count"}, int'(count), model);
    endtask

    task automatic t_reset();
        cycle(1'b1, 1'b0, 1'b0, "R1");
        cycle(1'b1, 1'b0, 1'b0, "R1");
    endtask

    task automatic t_up_wrap();
        for (int i = 0; i < MOD + 2; i++) cycle(1'b0, 1'b1, 1'b0, "R2/R6");
    endtask

    task automatic t_down_wrap();
        cycle(1'b1, 1'b0, 1'b0, "R1");
        for (int i = 0; i < MOD + 2; i++) cycle(1'b0, 1'b0, 1'b1, "R3");
    endtask

    task automatic t_edge_reverse();
        cycle(1'b1, 1'b0, 1'b0, "R1");
        cycle(1'b0, 1'b0, 1'b1, "R3");
        cycle(1'b0, 1'b1, 1'b0, "R6");
        cycle(1'b0, 1'b0, 1'b1, "R3");
        cycle(1'b0, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_hold();
        cycle(1'b0, 1'b1, 1'b0, "R2");
        cycle(1'b0, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_clash();
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 1'b1, "R5");
        cycle(1'b0, 1'b0, 1'b1, "R5");
    endtask

    task automatic t_reset_priority();
        cycle(1'b0, 1'b1, 1'b0, "R2");
        cycle(1'b1, 1'b1, 1'b0, "R7");
        cycle(1'b0, 1'b0, 1'b1, "R3");
        cycle(1'b1, 1'b0, 1'b1, "R7");
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            int sel = int'($urandom_range(0, 2));
            cycle(1'b0, sel == 1, sel == 2, "R2/R3/R4");
        end
    endtask

    initial begin
        t_reset();
        t_up_wrap();
        t_down_wrap();
        t_edge_reverse();
        t_hold();
        t_clash();
        t_reset_priority();
        t_random();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule